// File: doc/BRIEF.md
# CPU Injection Frame Builder

This block takes one frame at a time from a processor-side source and writes it into a switch injection queue as a series of 32-bit words. The queue has two write ports. Data words go through one port. Control words, which mark the start and end of a frame, go through the other port. A frame begins with a descriptor handshake. The descriptor carries the byte length and the fields of the internal header: destination port mask, pop count, CPU queue mask, tag type and analyzer bypass. The payload words follow on a separate valid/ready stream.

For each frame the block writes the following, in order:
1. A start control word.
2. A 128-bit internal header, sent as four data words with the most significant word first.
3. The payload words.
4. Zero words, if needed, so that at least one 60-byte cell (15 words) of payload has been written.
5. An end control word that reports the valid bytes in the last word.
6. One trailing zero word, which holds the place of the checksum.

No new descriptor is accepted until the trailing word has been written.

Top module: `injFrameBuilder`

## Requirements
- R1: The first write after a descriptor is accepted is a control write of 0x00240000: gap size 1 in bits 31:21, start flag in bit 18, all other bits zero.
- R2: The next four writes are data writes carrying the 128-bit header, bits 127:96 first. In the first header word, bit 31 equals the bypass input latched with the descriptor and all other bits are zero.
- R3: Destination mask bits 11:8 appear in bits 3:0 of header word 1, and mask bits 7:0 in bits 31:24 of header word 2. In header word 3, the pop count sits in bits 29:28, the CPU queue mask in bits 27:20 and the tag type in bit 16 (0 = C-tag, 1 = S-tag). All other header bits are zero.
- R4: After the header, ceil(length/4) payload words are written unchanged and in order. Each word is taken on a cycle with inValid and inReady both high. inReady is high only during the payload phase, so a gap on inValid stalls the block.
- R5: When fewer than 15 payload words were written, zero data words follow until 15 words in total have been written.
- R6: The end control word has gap size 1 in bits 31:21 and the end flag in bit 19. Bits 17:16 hold length mod 4 when the length is 60 bytes or more, and 0 when it is shorter.
- R7: Exactly one zero data write follows the end control word. The block is then idle.
- R8: startReady is high only when the block is idle, including straight after reset. The descriptor fields are captured when it is accepted, and changes to those inputs afterwards do not affect the frame.
- R9: A data write and a control write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Descriptor valid |
| startReady | output | 1 | Descriptor accepted when high (idle) |
| startLen | input | LEN_W | Frame length in bytes |
| cfgDestMask | input | 12 | Destination port mask |
| cfgPopCnt | input | 2 | Pop count (3 disables rewriting) |
| cfgQueueMask | input | 8 | CPU extraction queue mask |
| cfgTagType | input | 1 | Tag type, 0 C-tag, 1 S-tag |
| cfgBypass | input | 1 | Bypass analyzer processing |
| inValid | input | 1 | Payload word valid |
| inReady | output | 1 | Payload word accepted when high |
| inData | input | 32 | Payload word |
| qWrEn | output | 1 | Queue data write strobe |
| qWrData | output | 32 | Queue data word |
| qCtrlEn | output | 1 | Queue control write strobe |
| qCtrlData | output | 32 | Queue control word |

## Verification
Three events can coincide in one cycle:
- the handshake of the last payload word;
- the decision between padding and going straight to the end control word;
- the cell-size test that chooses the valid-byte count.

The bench provokes this coincidence with lengths of 56, 57, 59, 60, 61 and 63 bytes. In some frames it also idles inValid just before the last word, so the handshake arrives late. Each frame's complete write log is compared, entry by entry, with a sequence built in the bench from the length. Any missing or surplus pad word, or a wrong valid-byte count, therefore shows up as a miscompare.

// File: rtl/injFrmPkg.sv
package injFrmPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SOF,
    ST_HDR,
    ST_PAY,
    ST_PAD,
    ST_EOF,
    ST_TRAIL
  } injState_e;

  // strobes from control to datapath, one action per cycle
  typedef struct packed {
    logic       latchDesc;
    logic       sendSof;
    logic       sendHdr;
    logic [1:0] hdrIdx;
    logic       sendPay;
    logic       sendPad;
    logic       sendEof;
    logic       sendTrail;
  } injStrobe_t;

  localparam int CTRL_GAP_LSB = 21;
  localparam int CTRL_EOF_BIT = 19;
  localparam int CTRL_SOF_BIT = 18;
  localparam int CTRL_VB_LSB  = 16;
  localparam int HDR_WORDS    = 4;

endpackage

// File: rtl/injFrmCtrl.sv
module injFrmCtrl
  import injFrmPkg::*;
#(
  parameter int LEN_W      = 11,
  parameter int CELL_WORDS = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [LEN_W-1:0] startLen,
  output logic             startReady,
  input  logic             inValid,
  output logic             inReady,
  output injStrobe_t       strobe
);

  localparam logic [LEN_W-1:0] CELL_W = LEN_W'(CELL_WORDS);

  injState_e        state;
  logic [LEN_W-1:0] payWords;
  logic [LEN_W-1:0] wordCnt;
  logic [LEN_W-1:0] wordNext;
  logic [LEN_W:0]   lenRound;
  logic [1:0]       hdrCnt;

  assign lenRound = {1'b0, startLen} + (LEN_W+1)'(3);
  assign wordNext = wordCnt + 1'b1;

  always_comb begin
    strobe     = '0;
    startReady = (state == ST_IDLE);
    inReady    = (state == ST_PAY);
    case (state)
      ST_IDLE:  strobe.latchDesc = startValid;
      ST_SOF:   strobe.sendSof   = 1'b1;
      ST_HDR: begin
        strobe.sendHdr = 1'b1;
        strobe.hdrIdx  = hdrCnt;
      end
      ST_PAY:   strobe.sendPay   = inValid;
      ST_PAD:   strobe.sendPad   = 1'b1;
      ST_EOF:   strobe.sendEof   = 1'b1;
      ST_TRAIL: strobe.sendTrail = 1'b1;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      payWords <= '0;
      wordCnt  <= '0;
      hdrCnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (startValid) begin
          payWords <= LEN_W'(lenRound[LEN_W:2]);
          state    <= ST_SOF;
        end
        ST_SOF: begin
          hdrCnt <= '0;
          state  <= ST_HDR;
        end
        ST_HDR: begin
          hdrCnt <= hdrCnt + 1'b1;
          if (hdrCnt == 2'd3) begin
            wordCnt <= '0;
            state   <= (payWords == '0) ? ST_PAD : ST_PAY;
          end
        end
        ST_PAY: if (inValid) begin
          wordCnt <= wordNext;
          if (wordNext == payWords)
            state <= (wordNext < CELL_W) ? ST_PAD : ST_EOF;
        end
        ST_PAD: begin
          wordCnt <= wordNext;
          if (wordNext >= CELL_W) state <= ST_EOF;
        end
        ST_EOF:   state <= ST_TRAIL;
        ST_TRAIL: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R1
  sof_then_hdr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sendSof |=> (strobe.sendHdr && strobe.hdrIdx == 2'd0));

  // R7
  eof_then_trail_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sendEof |=> (strobe.sendTrail && !startReady));

  // R7
  trail_then_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sendTrail |=> startReady);

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchDesc |=> (!startReady && strobe.sendSof));

  // R5
  pad_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sendPad |-> (wordCnt < CELL_W));

  // R4
  ready_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && startReady));

endmodule

// File: rtl/injFrmData.sv
module injFrmData
  import injFrmPkg::*;
#(
  parameter int LEN_W      = 11,
  parameter int CELL_BYTES = 60,
  parameter int GAP        = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  injStrobe_t       strobe,
  input  logic [LEN_W-1:0] startLen,
  input  logic [11:0]      cfgDestMask,
  input  logic [1:0]       cfgPopCnt,
  input  logic [7:0]       cfgQueueMask,
  input  logic             cfgTagType,
  input  logic             cfgBypass,
  input  logic [31:0]      inData,
  output logic             qWrEn,
  output logic [31:0]      qWrData,
  output logic             qCtrlEn,
  output logic [31:0]      qCtrlData
);

  localparam logic [LEN_W-1:0] CELL_LEN = LEN_W'(CELL_BYTES);
  localparam logic [31:0] GAP_FIELD = 32'(GAP) << CTRL_GAP_LSB;

  logic [LEN_W-1:0] lenR;
  logic [11:0]      maskR;
  logic [1:0]       popR;
  logic [7:0]       queueR;
  logic             tagR;
  logic             bypR;
  logic [1:0]       validBytes;
  logic [31:0]      hdrWord [HDR_WORDS];
  logic [31:0]      sofWord;
  logic [31:0]      eofWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenR   <= '0;
      maskR  <= '0;
      popR   <= '0;
      queueR <= '0;
      tagR   <= 1'b0;
      bypR   <= 1'b0;
    end else if (strobe.latchDesc) begin
      lenR   <= startLen;
      maskR  <= cfgDestMask;
      popR   <= cfgPopCnt;
      queueR <= cfgQueueMask;
      tagR   <= cfgTagType;
      bypR   <= cfgBypass;
    end
  end

  // header bits 127..0 split into four words, most significant first
  assign hdrWord[0] = {bypR, 31'b0};
  assign hdrWord[1] = {28'b0, maskR[11:8]};
  assign hdrWord[2] = {maskR[7:0], 24'b0};
  assign hdrWord[3] = {2'b0, popR, queueR, 3'b0, tagR, 16'b0};

  assign validBytes = (lenR >= CELL_LEN) ? lenR[1:0] : 2'b0;
  assign sofWord    = GAP_FIELD | (32'd1 << CTRL_SOF_BIT);
  assign eofWord    = GAP_FIELD | (32'd1 << CTRL_EOF_BIT)
                    | (32'(validBytes) << CTRL_VB_LSB);

  always_comb begin
    qWrEn     = strobe.sendHdr | strobe.sendPay | strobe.sendPad | strobe.sendTrail;
    qCtrlEn   = strobe.sendSof | strobe.sendEof;
    qWrData   = '0;
    qCtrlData = '0;
    if (strobe.sendHdr)      qWrData = hdrWord[strobe.hdrIdx];
    else if (strobe.sendPay) qWrData = inData;
    if (strobe.sendSof)      qCtrlData = sofWord;
    else if (strobe.sendEof) qCtrlData = eofWord;
  end

  // R9
  one_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(qWrEn && qCtrlEn));

  // R6
  short_vb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (qCtrlEn && qCtrlData[CTRL_EOF_BIT] && lenR < CELL_LEN)
      |-> (qCtrlData[CTRL_VB_LSB+1:CTRL_VB_LSB] == 2'b0));

endmodule

// File: rtl/injFrameBuilder.sv
module injFrameBuilder
  import injFrmPkg::*;
#(
  parameter int LEN_W      = 11,
  parameter int CELL_BYTES = 60,
  parameter int GAP        = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  output logic             startReady,
  input  logic [LEN_W-1:0] startLen,
  input  logic [11:0]      cfgDestMask,
  input  logic [1:0]       cfgPopCnt,
  input  logic [7:0]       cfgQueueMask,
  input  logic             cfgTagType,
  input  logic             cfgBypass,
  input  logic             inValid,
  output logic             inReady,
  input  logic [31:0]      inData,
  output logic             qWrEn,
  output logic [31:0]      qWrData,
  output logic             qCtrlEn,
  output logic [31:0]      qCtrlData
);

  localparam int CELL_WORDS = CELL_BYTES / 4;

  injStrobe_t strobe;

  injFrmCtrl #(.LEN_W(LEN_W), .CELL_WORDS(CELL_WORDS)) ctrlU (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startLen(startLen),
    .startReady(startReady), .inValid(inValid), .inReady(inReady),
    .strobe(strobe)
  );

  injFrmData #(.LEN_W(LEN_W), .CELL_BYTES(CELL_BYTES), .GAP(GAP)) dataU (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startLen(startLen),
    .cfgDestMask(cfgDestMask), .cfgPopCnt(cfgPopCnt),
    .cfgQueueMask(cfgQueueMask), .cfgTagType(cfgTagType),
    .cfgBypass(cfgBypass), .inData(inData), .qWrEn(qWrEn),
    .qWrData(qWrData), .qCtrlEn(qCtrlEn), .qCtrlData(qCtrlData)
  );

endmodule

// File: tb/injFrameBuilder_test.sv
module injFrameBuilder_test;

  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 11;
  localparam int NVEC       = 10;
  localparam int LOG_D      = 64;

  // {len, destMask, pop, queueMask, tag, bypass, stallBeforeLast}
  localparam logic [35:0] VEC [NVEC] = '{
    {11'd1,   12'h001, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0},
    {11'd4,   12'hA5C, 2'd3, 8'hFF, 1'b1, 1'b1, 1'b1},
    {11'd56,  12'h800, 2'd1, 8'h01, 1'b0, 1'b0, 1'b0},
    {11'd57,  12'h0F0, 2'd2, 8'h80, 1'b1, 1'b1, 1'b1},
    {11'd59,  12'h3C3, 2'd3, 8'h5A, 1'b0, 1'b1, 1'b0},
    {11'd60,  12'hFFF, 2'd0, 8'h7E, 1'b1, 1'b0, 1'b1},
    {11'd61,  12'h123, 2'd1, 8'h11, 1'b0, 1'b1, 1'b0},
    {11'd63,  12'h456, 2'd2, 8'h22, 1'b1, 1'b1, 1'b1},
    {11'd64,  12'h789, 2'd3, 8'h33, 1'b0, 1'b0, 1'b0},
    {11'd102, 12'hABC, 2'd0, 8'h44, 1'b1, 1'b1, 1'b1}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startValid = 1'b0;
  logic             startReady;
  logic [LEN_W-1:0] startLen = '0;
  logic [11:0]      cfgDestMask = '0;
  logic [1:0]       cfgPopCnt = '0;
  logic [7:0]       cfgQueueMask = '0;
  logic             cfgTagType = 1'b0;
  logic             cfgBypass = 1'b0;
  logic             inValid = 1'b0;
  logic             inReady;
  logic [31:0]      inData = '0;
  logic             qWrEn;
  logic [31:0]      qWrData;
  logic             qCtrlEn;
  logic [31:0]      qCtrlData;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit logging = 1'b0;
  int logCnt = 0;
  logic [32:0] logMem [LOG_D];
  logic [32:0] expMem [LOG_D];

  always #(CLK_PERIOD/2) clk = ~clk;

  injFrameBuilder #(.LEN_W(LEN_W)) uut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startReady(startReady),
    .startLen(startLen), .cfgDestMask(cfgDestMask), .cfgPopCnt(cfgPopCnt),
    .cfgQueueMask(cfgQueueMask), .cfgTagType(cfgTagType), .cfgBypass(cfgBypass),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .qWrEn(qWrEn), .qWrData(qWrData), .qCtrlEn(qCtrlEn), .qCtrlData(qCtrlData)
  );

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d cycles expected=finish", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // monitor samples at the falling edge
  always @(negedge clk) begin
    if (logging) begin
      if (qWrEn && qCtrlEn) check("R9 both ports", 33'd1, 33'd0);
      if (qWrEn || qCtrlEn) begin
        check("R8 startReady while writing", 33'(startReady), 33'd0);
        if (logCnt < LOG_D) logMem[logCnt] = {qCtrlEn, qCtrlEn ? qCtrlData : qWrData};
        logCnt++;
      end
    end
  end

  function automatic logic [31:0] payWord(input int len, input int w);
    return {8'(len), 8'hC3, 16'(w)};
  endfunction

  task automatic runVec(input logic [35:0] v);
    int len, n, total, pad, eofIdx;
    logic [11:0] mask;
    logic [1:0] pop;
    logic [7:0] qm;
    logic tag, byp, stall, acc;
    string tagName;
    len = int'(v[35:25]); mask = v[24:13]; pop = v[12:11]; qm = v[10:3];
    tag = v[2]; byp = v[1]; stall = v[0];
    n = (len + 3) / 4;
    pad = (n < 15) ? 15 - n : 0;
    // expected log
    expMem[0] = {1'b1, 32'h0024_0000};
    expMem[1] = {1'b0, byp, 31'b0};
    expMem[2] = {1'b0, 28'b0, mask[11:8]};
    expMem[3] = {1'b0, mask[7:0], 24'b0};
    expMem[4] = {1'b0, 2'b0, pop, qm, 3'b0, tag, 16'b0};
    for (int w = 0; w < n; w++) expMem[5+w] = {1'b0, payWord(len, w)};
    for (int p = 0; p < pad; p++) expMem[5+n+p] = 33'd0;
    eofIdx = 5 + n + pad;
    expMem[eofIdx] = {1'b1, 32'h0028_0000 | ((len >= 60) ? 32'(len % 4) << 16 : 32'd0)};
    expMem[eofIdx+1] = 33'd0;
    total = eofIdx + 2;
    logCnt = 0;
    logging = 1'b1;
    // descriptor
    @(posedge clk); #1;
    startValid = 1'b1; startLen = LEN_W'(len); cfgDestMask = mask; cfgPopCnt = pop;
    cfgQueueMask = qm; cfgTagType = tag; cfgBypass = byp;
    @(negedge clk);
    check("R8 startReady idle", 33'(startReady), 33'd1);
    @(posedge clk); #1;
    startValid = 1'b0;
    // scramble descriptor inputs after acceptance (R8)
    startLen = ~startLen; cfgDestMask = ~mask; cfgPopCnt = ~pop;
    cfgQueueMask = ~qm; cfgTagType = ~tag; cfgBypass = ~byp;
    for (int w = 0; w < n; w++) begin
      if (stall && w == n - 1) begin
        inValid = 1'b0;
        @(posedge clk); #1;
      end
      inValid = 1'b1;
      inData = payWord(len, w);
      forever begin
        @(negedge clk);
        acc = inReady;
        @(posedge clk); #1;
        if (acc) break;
      end
    end
    inValid = 1'b0;
    inData = 32'hDEAD_BEEF;
    forever begin
      @(negedge clk);
      if (startReady) break;
    end
    logging = 1'b0;
    check("R7 write count", 33'(logCnt), 33'(total));
    for (int i = 0; i < total && i < logCnt; i++) begin
      if (i == 0) tagName = "R1 start ctrl";
      else if (i == 1) tagName = "R2 header word0";
      else if (i < 5) tagName = "R3 header field";
      else if (i < 5 + n) tagName = "R4 payload";
      else if (i < eofIdx) tagName = "R5 pad";
      else if (i == eofIdx) tagName = "R6 end ctrl";
      else tagName = "R7 trailing";
      check($sformatf("%s len=%0d idx=%0d", tagName, len, i), logMem[i], expMem[i]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // reset state
    check("R8 reset startReady", 33'(startReady), 33'd1);
    check("R4 reset inReady", 33'(inReady), 33'd0);
    check("R9 reset qWrEn", 33'(qWrEn), 33'd0);
    check("R1 reset qCtrlEn", 33'(qCtrlEn), 33'd0);
    for (int k = 0; k < NVEC; k++) runVec(VEC[k]);
    // directed: one more short frame straight after a long one, with stall
    runVec({11'd8, 12'h5A5, 2'd1, 8'h0F, 1'b1, 1'b0, 1'b1});
    // idle: nothing written, ready stays low for payload
    @(negedge clk);
    check("R4 idle inReady", 33'(inReady), 33'd0);
    check("R7 idle no write", 33'(qWrEn | qCtrlEn), 33'd0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule